// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces addresses for indirect memory accesses in a DSP datapath. It holds four index pointers, four modify registers and four length registers. On each access the selected pointer is presented as the address. In the same cycle the pointer is updated by one of the four modify values, which is chosen independently of the pointer. The update is a post-modify: the address seen on the access is the value before the update.

When the length paired with a pointer is non-zero, the update stays inside a circular buffer. The buffer base is the pointer with its low bits cleared. The number of bits cleared is set by the smallest power of two that is at least the length. A step that leaves the window [base, base+length-1] is folded back by one length. When the length is zero the pointer steps linearly, modulo 2^14.

An access uses a valid/ready pair. Ready drops only when software writes the very pointer the access selects in that cycle. The write wins, and the requester holds its request and retries on the next cycle, where it sees the written value. The address and its valid flag are combinational from the current register state.

Top module: `dag_top`

## Requirements
- R1: After reset all index, modify and length registers are zero, so the address for every pointer select is 0 and acc_ready is 1 with no write pending.
- R2: addr_o always equals the current value of the pointer chosen by acc_psel. addr_vld equals acc_valid AND acc_ready.
- R3: With length zero, an accepted access sets the pointer to (pointer + modify) modulo 2^14 on the next clock edge.
- R4: Modify values are 14-bit two's complement. A value with bit 13 set steps the pointer backward.
- R5: With a non-zero length L, the buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two not below L. The updated pointer is base + offset, with the offset in [0, L-1]. This is guaranteed when |modify| <= L and the pointer starts inside its buffer.
- R6: In circular mode, an offset plus modify that reaches L or more has L subtracted.
- R7: In circular mode, an offset plus modify below zero has L added.
- R8: Any modify register may pair with any pointer. An access changes only the selected pointer.
- R9: An index write is visible on addr_o on the cycle after the write. If the write targets the pointer a valid access selects in the same cycle, acc_ready is 0, the access is not taken, and the pointer takes the written value.
- R10: A write to a modify or length register in the same cycle as an access does not affect that access. The new value applies from the next cycle.
- R11: With acc_valid low, no pointer changes. acc_ready is 1 whenever no index write targets the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| idx_we | input | 1 | Index register write enable |
| idx_wsel | input | 2 | Index register write select |
| idx_wdata | input | 14 | Index register write data |
| mod_we | input | 1 | Modify register write enable |
| mod_wsel | input | 2 | Modify register write select |
| mod_wdata | input | 14 | Modify value, two's complement |
| len_we | input | 1 | Length register write enable |
| len_wsel | input | 2 | Length register write select |
| len_wdata | input | 14 | Buffer length, 0 = linear |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_psel | input | 2 | Pointer select for the access |
| acc_msel | input | 2 | Modify register select for the access |
| addr_o | output | 14 | Address: selected pointer before update |
| addr_vld | output | 1 | Access accepted this cycle |

## Verification
Two things can fall in the same cycle: a software write to an index register and an access that post-modifies that same pointer. The bench drives both together on one pointer. It expects ready low, no accepted address, and the written value on the next cycle with no modify applied. It then repeats the pair on different pointers, where both must take effect. Writes to modify and length registers that coincide with an access are judged the same way: the access must use the old values and the next access the new ones.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int DAG_AW   = 14;
  localparam int DAG_NPTR = 4;
  localparam int DAG_NMOD = 4;

  typedef enum logic [0:0] {
    BANK_PLAIN  = 1'b0,
    BANK_UPDATE = 1'b1
  } bank_kind_e;
endpackage

// File: rtl/dag_bank.sv
module dag_bank
  import dag_pkg::*;
#(
  parameter int         N    = 4,
  parameter int         W    = 14,
  parameter bank_kind_e KIND = BANK_PLAIN,
  localparam int        SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [W-1:0]  upd_data,
  output logic [W-1:0]  rd [N]
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] q;
    logic         hit_w;
    assign hit_w = we && (wsel == SW'(g));

    if (KIND == BANK_UPDATE) begin : g_upd
      logic hit_u;
      assign hit_u = upd_en && (upd_sel == SW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (hit_w) q <= wdata;       // software write has priority
        else if (hit_u) q <= upd_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (hit_w) q <= wdata;
      end
    end
    assign rd[g] = q;
  end

endmodule

// File: rtl/dag_wrap.sv
module dag_wrap #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);

  logic        [AW-1:0] mask;
  logic        [AW-1:0] base;
  logic        [AW-1:0] off;
  logic signed [AW+1:0] soff;
  logic signed [AW+1:0] slen;
  logic signed [AW+1:0] fold;
  logic        [AW-1:0] circ;
  logic        [AW-1:0] lin;

  always_comb begin
    // smallest power of two >= len, minus one: smear (len-1) downward
    mask = len - AW'(1);
    for (int s = 1; s < AW; s = s * 2) begin
      mask = mask | (mask >> s);
    end
    base = ptr & ~mask;
    off  = ptr & mask;
    slen = $signed({2'b00, len});
    soff = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
    if (soff >= slen)      fold = soff - slen;
    else if (soff < 0)     fold = soff + slen;
    else                   fold = soff;
    circ = base + fold[AW-1:0];
    lin  = ptr + step;
    nxt  = (len == '0) ? lin : circ;
  end

endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int  AW   = DAG_AW,
  parameter int  NPTR = DAG_NPTR,
  parameter int  NMOD = DAG_NMOD,
  localparam int PSW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int MSW  = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           idx_we,
  input  logic [PSW-1:0] idx_wsel,
  input  logic [AW-1:0]  idx_wdata,
  input  logic           mod_we,
  input  logic [MSW-1:0] mod_wsel,
  input  logic [AW-1:0]  mod_wdata,
  input  logic           len_we,
  input  logic [PSW-1:0] len_wsel,
  input  logic [AW-1:0]  len_wdata,
  input  logic           acc_valid,
  output logic           acc_ready,
  input  logic [PSW-1:0] acc_psel,
  input  logic [MSW-1:0] acc_msel,
  output logic [AW-1:0]  addr_o,
  output logic           addr_vld
);

  logic [AW-1:0] idx_q [NPTR];
  logic [AW-1:0] mod_q [NMOD];
  logic [AW-1:0] len_q [NPTR];
  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] cur_mod;
  logic [AW-1:0] cur_len;
  logic [AW-1:0] nxt_ptr;

  // a write to the selected pointer wins; the access waits one cycle
  assign acc_ready = !(idx_we && (idx_wsel == acc_psel));
  assign addr_vld  = acc_valid && acc_ready;

  assign cur_ptr = idx_q[acc_psel];
  assign cur_len = len_q[acc_psel];
  assign cur_mod = mod_q[acc_msel];
  assign addr_o  = cur_ptr;

  dag_bank #(.N(NPTR), .W(AW), .KIND(BANK_UPDATE)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (idx_we),
    .wsel     (idx_wsel),
    .wdata    (idx_wdata),
    .upd_en   (addr_vld),
    .upd_sel  (acc_psel),
    .upd_data (nxt_ptr),
    .rd       (idx_q)
  );

  dag_bank #(.N(NMOD), .W(AW), .KIND(BANK_PLAIN)) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mod_we),
    .wsel     (mod_wsel),
    .wdata    (mod_wdata),
    .upd_en   (1'b0),
    .upd_sel  ('0),
    .upd_data ('0),
    .rd       (mod_q)
  );

  dag_bank #(.N(NPTR), .W(AW), .KIND(BANK_PLAIN)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (len_we),
    .wsel     (len_wsel),
    .wdata    (len_wdata),
    .upd_en   (1'b0),
    .upd_sel  ('0),
    .upd_data ('0),
    .rd       (len_q)
  );

  dag_wrap #(.AW(AW)) u_wrap (
    .ptr  (cur_ptr),
    .step (cur_mod),
    .len  (cur_len),
    .nxt  (nxt_ptr)
  );

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int AW  = 14,
  parameter int PSW = 2,
  parameter int MSW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           idx_we,
  input logic [PSW-1:0] idx_wsel,
  input logic [AW-1:0]  idx_wdata,
  input logic           acc_valid,
  input logic           acc_ready,
  input logic [PSW-1:0] acc_psel,
  input logic [MSW-1:0] acc_msel,
  input logic [AW-1:0]  addr_o,
  input logic           addr_vld
);

  // R9: a write to the selected pointer stalls the access
  a_r9_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && idx_wsel == acc_psel) |-> (!acc_ready && !addr_vld));

  // R9: written index value visible next cycle
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (acc_psel != $past(idx_wsel) || addr_o == $past(idx_wdata)));

  // R11: ready stays high when no write hits the selected pointer
  a_r11_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_we && idx_wsel == acc_psel) |-> acc_ready);

  // R11: with no access and no write, the observed pointer holds
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !idx_we) |=> (acc_psel != $past(acc_psel) || addr_o == $past(addr_o)));

  // R2: an accepted access needs a request
  a_r2_vld_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> acc_valid);

endmodule

bind dag_top dag_chk #(.AW(AW), .PSW(PSW), .MSW(MSW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_we    (idx_we),
  .idx_wsel  (idx_wsel),
  .idx_wdata (idx_wdata),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_psel  (acc_psel),
  .acc_msel  (acc_msel),
  .addr_o    (addr_o),
  .addr_vld  (addr_vld)
);

// File: tb/sim_dag_top.sv
module sim_dag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 0, mod_we = 0, len_we = 0, acc_valid = 0;
  logic [1:0]  idx_wsel = 0, mod_wsel = 0, len_wsel = 0, acc_psel = 0, acc_msel = 0;
  logic [13:0] idx_wdata = 0, mod_wdata = 0, len_wdata = 0;
  logic        acc_ready, addr_vld;
  logic [13:0] addr_o;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dag_top u0 (.*);

  // {psel, msel, expected address}
  localparam logic [17:0] VEC [14] = '{
    {2'd0, 2'd0, 14'h0023}, {2'd0, 2'd0, 14'h0027}, {2'd0, 2'd1, 14'h0021},
    {2'd0, 2'd3, 14'h0028}, {2'd1, 2'd1, 14'h0100}, {2'd1, 2'd3, 14'h00FD},
    {2'd2, 2'd0, 14'h3FFE}, {2'd2, 2'd1, 14'h0002}, {2'd3, 2'd3, 14'h0047},
    {2'd3, 2'd1, 14'h0046}, {2'd3, 2'd1, 14'h0043}, {2'd3, 2'd1, 14'h0040},
    {2'd0, 2'd2, 14'h0025}, {2'd0, 2'd2, 14'h0025}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int bank, input logic [1:0] sel, input logic [13:0] d);
    @(negedge clk);
    case (bank)
      0: begin idx_we = 1; idx_wsel = sel; idx_wdata = d; end
      1: begin mod_we = 1; mod_wsel = sel; mod_wdata = d; end
      default: begin len_we = 1; len_wsel = sel; len_wdata = d; end
    endcase
    @(posedge clk); #1;
    idx_we = 0; mod_we = 0; len_we = 0;
  endtask

  task automatic peek(input string tag, input logic [1:0] p, input logic [13:0] exp);
    @(negedge clk);
    acc_valid = 0; acc_psel = p;
    #1 chk(tag, addr_o, exp);
  endtask

  // drive an access at the falling edge, check before the rising edge
  task automatic acc(input string tag, input logic [1:0] p, input logic [1:0] m,
                     input logic [13:0] exp);
    @(negedge clk);
    acc_valid = 1; acc_psel = p; acc_msel = m;
    #1 chk(tag, addr_o, exp);
    chk({tag, " vld"}, addr_vld, 1'b1);
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int p = 0; p < 4; p++) peek("R1 reset addr", 2'(p), 14'h0);
    chk("R1 ready after reset", acc_ready, 1'b1);

    wr(2, 0, 14'd10); wr(2, 3, 14'd8);
    wr(0, 0, 14'h0023); wr(0, 1, 14'h0100); wr(0, 2, 14'h3FFE); wr(0, 3, 14'h0047);
    wr(1, 0, 14'd4); wr(1, 1, 14'h3FFD); wr(1, 2, 14'd0); wr(1, 3, 14'd7);
    peek("R9 index write visible", 0, 14'h0023);

    // table walk: R3 R4 R5 R6 R7 R8 post-modify sequence
    for (int i = 0; i < 14; i++)
      acc("R5/R6/R7 table addr", VEC[i][17:16], VEC[i][15:14], VEC[i][13:0]);
    peek("R8 final p0", 0, 14'h0025);
    peek("R3 final p1 linear", 1, 14'h0104);
    peek("R4 final p2 backward", 2, 14'h3FFF);
    peek("R7 final p3 under base", 3, 14'h0045);

    // R9 collision: write and access to same pointer
    @(negedge clk);
    idx_we = 1; idx_wsel = 1; idx_wdata = 14'h0200;
    acc_valid = 1; acc_psel = 1; acc_msel = 0;
    #1 chk("R9 ready low on collision", acc_ready, 1'b0);
    chk("R9 no accept on collision", addr_vld, 1'b0);
    @(posedge clk); #1 idx_we = 0; acc_valid = 0;
    peek("R9 write wins", 1, 14'h0200);

    // R11 write to other pointer leaves access free
    @(negedge clk);
    idx_we = 1; idx_wsel = 2; idx_wdata = 14'h0010;
    acc_valid = 1; acc_psel = 0; acc_msel = 2;
    #1 chk("R11 ready with other write", acc_ready, 1'b1);
    @(posedge clk); #1 idx_we = 0; acc_valid = 0;
    peek("R11 other write lands", 2, 14'h0010);

    // R10 modify write coincident with access uses old modify
    @(negedge clk);
    mod_we = 1; mod_wsel = 0; mod_wdata = 14'd100;
    acc_valid = 1; acc_psel = 1; acc_msel = 0;
    @(posedge clk); #1 mod_we = 0; acc_valid = 0;
    peek("R10 old modify used", 1, 14'h0204);
    acc("R10 new modify addr", 1, 0, 14'h0204);
    peek("R10 new modify applied", 1, 14'h0268);

    // R10 length write coincident with access uses old length
    @(negedge clk);
    len_we = 1; len_wsel = 3; len_wdata = 14'd0;
    acc_valid = 1; acc_psel = 3; acc_msel = 3;
    @(posedge clk); #1 len_we = 0; acc_valid = 0;
    peek("R10 old length used", 3, 14'h0044);
    acc("R3 linear after length cleared", 3, 3, 14'h0044);
    peek("R3 linear step", 3, 14'h004B);

    // R11 idle cycles change nothing
    repeat (3) @(posedge clk);
    peek("R11 idle hold", 3, 14'h004B);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule